// File: doc/BRIEF.md
# Rate Sensor Command Frame Engine

This block is an SPI master that talks to a digital angular-rate sensor using fixed 32-bit command and reply frames. A client hands it one request at a time over a valid/ready handshake. There are three kinds of request: fetch the current rate sample, read a 16-bit register pair, or write a 16-bit register pair. The block builds the command word, including an odd-parity bit, and drives the serial pins directly in SPI mode 0.

The sensor answers a command during the frame that follows it. For this reason, every read runs two chip-select frames with a short idle gap between them. The second frame carries zeros on MOSI and brings back the reply. The block then pulls the data, status and error fields out of the reply and presents them for one cycle. A write is a single frame. After it, the block refuses new work until a quiet interval of at least 0.1 ms has passed.

The SCK rate, the inter-frame gap and the write quiet interval all come from parameters in terms of the system clock frequency.

Top module: `rate_sensor_spi_master`

## Requirements
- R1: Each frame has exactly 32 SCK pulses inside one low period of `cs_n`. Bits are sent most significant first. SCK rests low. MOSI changes only while SCK is low, and MISO is sampled on the SCK rising edge.
- R2: Request kind 2'b00 (rate sample) sends opcode 3'b001 in command bits 31:29. Kind 2'b01 (register read) sends 3'b100. Kind 2'b10 (register write) sends 3'b010.
- R3: For register requests, command bits 24:17 carry the address with its LSB forced to 0, so an odd address selects its even pair. Bits 28:25 are zero. A rate-sample command has zeros in bits 28:1.
- R4: A register write puts the 16-bit write value in command bits 16:1. Reads leave those bits zero.
- R5: Command bit 0 is set exactly when bits 31:1 hold an even number of ones, so every command word has odd weight.
- R6: Both read kinds run two frames. `cs_n` stays high for at least GAP_NS between them, and MOSI is all zeros during the second frame.
- R7: For a register read, `rsp_data` is reply bits 20:5.
- R8: For a rate sample, `rsp_data` is reply bits 25:10, passed unchanged as a two's-complement value.
- R9: At the end of each read, `rsp_valid` pulses for one cycle. It comes with `rsp_status` = reply bits 27:26, `rsp_error` = reply bits 31:29 and `rsp_raw` = the full reply.
- R10: A write runs one frame and raises no `rsp_valid`. `req_ready` stays low for at least QUIET_NS after `cs_n` rises.
- R11: `req_ready` is high only while the engine is idle with `cs_n` high. A request of kind 2'b11 is taken and dropped without any frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken on this cycle if valid |
| req_kind | input | 2 | 00 rate sample, 01 register read, 10 register write, 11 dropped |
| req_addr | input | 8 | Register pair address (LSB ignored) |
| req_wdata | input | 16 | Value for a register write |
| rsp_valid | output | 1 | One-cycle pulse when a read reply is decoded |
| rsp_data | output | 16 | Extracted register value or rate sample |
| rsp_status | output | 2 | Reply status field |
| rsp_error | output | 3 | Reply error-flag field |
| rsp_raw | output | 32 | Whole reply word |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the sensor |
| miso | input | 1 | Serial data from the sensor |

## Verification
The bench targets the cases where an off-by-one design would still appear to work:
- Parity words with both even and odd raw weight. An inverted parity rule sends even-weight commands that the sensor rejects.
- Odd register addresses. An engine that does not clear the LSB would address the wrong pair.
- Replies with a negative rate and all error bits set. A misplaced extraction window would shift these fields or lose their sign.
- The inter-frame gap and the write quiet interval, timed from chip-select edges. A short counter would let frames run closer together than the sensor tolerates.
- The kind 2'b11 request. A design that mishandles it starts a spurious frame.

// File: rtl/rate_sensor_spi_master.sv
module rate_sensor_spi_master #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int SCK_HZ   = 5_000_000,
  parameter int GAP_NS   = 1_000,
  parameter int QUIET_NS = 100_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_kind,
  input  logic [7:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  output logic [15:0] rsp_data,
  output logic [1:0]  rsp_status,
  output logic [2:0]  rsp_error,
  output logic [31:0] rsp_raw,
  output logic        sck,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);

  localparam int HALF_RAW  = CLK_HZ / (2 * SCK_HZ);
  localparam int HALF      = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int MHZ       = CLK_HZ / 1_000_000;
  localparam int GAP_RAW   = (MHZ * GAP_NS + 999) / 1000;
  localparam int QUIET_RAW = (MHZ * QUIET_NS + 999) / 1000;
  localparam int GAP_CYC   = (GAP_RAW < 1) ? 1 : GAP_RAW;
  localparam int QUIET_CYC = (QUIET_RAW < 1) ? 1 : QUIET_RAW;
  localparam int LONGEST   = (QUIET_CYC > GAP_CYC) ? QUIET_CYC : GAP_CYC;
  localparam int DW        = $clog2(HALF) + 1;
  localparam int GW        = $clog2(LONGEST) + 1;

  localparam logic [1:0] K_RATE  = 2'b00;
  localparam logic [1:0] K_READ  = 2'b01;
  localparam logic [1:0] K_WRITE = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} state_t;

  state_t         state;
  logic [31:0]    tx_sr, rx_sr, body, cmd;
  logic [DW-1:0]  div;
  logic [4:0]     bit_cnt;
  logic [GW-1:0]  gap_cnt;
  logic [1:0]     kind_q;
  logic           reply_phase;
  logic [2:0]     opcode;
  logic [7:0]     addr_f;

  always_comb begin
    unique case (req_kind)
      K_RATE:  opcode = 3'b001;
      K_READ:  opcode = 3'b100;
      K_WRITE: opcode = 3'b010;
      default: opcode = 3'b000;
    endcase
  end

  assign addr_f = (req_kind == K_RATE) ? 8'h00 : (req_addr & 8'hFE);
  assign body   = {opcode, 4'b0000, addr_f,
                   (req_kind == K_WRITE) ? req_wdata : 16'h0000, 1'b0};
  assign cmd    = {body[31:1], ~^body[31:1]};

  assign req_ready = (state == S_IDLE);
  assign mosi      = ~cs_n & tx_sr[31];

  wire half_done = (div == DW'(HALF - 1));
  wire last_bit  = (bit_cnt == 5'd31);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      tx_sr       <= '0;
      rx_sr       <= '0;
      div         <= '0;
      bit_cnt     <= '0;
      gap_cnt     <= '0;
      kind_q      <= K_RATE;
      reply_phase <= 1'b0;
      sck         <= 1'b0;
      cs_n        <= 1'b1;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_status  <= '0;
      rsp_error   <= '0;
      rsp_raw     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid && req_kind != 2'b11) begin
            tx_sr       <= cmd;
            kind_q      <= req_kind;
            reply_phase <= 1'b0;
            cs_n        <= 1'b0;
            div         <= '0;
            bit_cnt     <= '0;
            state       <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (!half_done) begin
            div <= div + 1'b1;
          end else begin
            div <= '0;
            if (!sck) begin
              sck   <= 1'b1;
              rx_sr <= {rx_sr[30:0], miso};
            end else begin
              sck <= 1'b0;
              if (last_bit) begin
                cs_n    <= 1'b1;
                state   <= S_GAP;
                gap_cnt <= (kind_q == K_WRITE) ? GW'(QUIET_CYC - 1) : GW'(GAP_CYC - 1);
                if (reply_phase) begin
                  rsp_valid  <= 1'b1;
                  rsp_raw    <= rx_sr;
                  rsp_status <= rx_sr[27:26];
                  rsp_error  <= rx_sr[31:29];
                  rsp_data   <= (kind_q == K_RATE) ? rx_sr[25:10] : rx_sr[20:5];
                end
              end else begin
                tx_sr   <= {tx_sr[30:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
        end
        S_GAP: begin
          if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
          end else if (!reply_phase && kind_q != K_WRITE) begin
            reply_phase <= 1'b1;
            tx_sr       <= '0;
            cs_n        <= 1'b0;
            div         <= '0;
            bit_cnt     <= '0;
            state       <= S_SHIFT;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rate_sensor_spi_master_sva.sv
module rate_sensor_spi_master_sva (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic cs_n,
  input logic mosi,
  input logic req_ready,
  input logic rsp_valid
);

  p_sck_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  p_rise_in_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> !cs_n);

  p_mosi_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_after_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (cs_n && !req_ready));

  p_ready_cs_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && !sck));

endmodule

bind rate_sensor_spi_master rate_sensor_spi_master_sva u_sva (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
  .req_ready(req_ready), .rsp_valid(rsp_valid)
);

// File: tb/sim_rate_sensor_spi_master.sv
module sim_rate_sensor_spi_master;

  localparam int CLK_HZ    = 50_000_000;
  localparam int GAP_NS    = 1_000;
  localparam int QUIET_NS  = 100_000;
  localparam int GAP_CYC   = 50;
  localparam int QUIET_CYC = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'b00;
  logic [7:0]  req_addr = 8'h00;
  logic [15:0] req_wdata = 16'h0000;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [1:0]  rsp_status;
  logic [2:0]  rsp_error;
  logic [31:0] rsp_raw;
  logic        sck, cs_n, mosi;
  logic        miso = 1'b0;

  always #10 clk = ~clk;

  rate_sensor_spi_master #(
    .CLK_HZ(CLK_HZ), .SCK_HZ(5_000_000), .GAP_NS(GAP_NS), .QUIET_NS(QUIET_NS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_status(rsp_status),
    .rsp_error(rsp_error), .rsp_raw(rsp_raw),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] slave_word = '0;
  logic [31:0] cap = '0;
  logic [31:0] frames [2];
  int          fbits [2];
  int          sidx = 0;
  int          nbits = 0;
  int          nfalls = 0;
  int          nrises = 0;
  int          rsp_cnt = 0;
  realtime     rise_t = 0, fall_t = 0, gap_t = 0;
  logic [15:0] got_data;
  logic [1:0]  got_status;
  logic [2:0]  got_error;
  logic [31:0] got_raw;

  always @(negedge cs_n) begin
    if (nfalls == 1) gap_t = $realtime - rise_t;
    fall_t = $realtime;
    nfalls++;
    cap = '0;
    nbits = 0;
    miso = slave_word[31];
    sidx = 30;
  end

  always @(negedge sck) begin
    if (!cs_n && sidx >= 0) begin
      miso = slave_word[sidx];
      sidx--;
    end
  end

  always @(posedge sck) begin
    if (!cs_n) begin
      cap = {cap[30:0], mosi};
      nbits++;
    end
  end

  always @(posedge cs_n) begin
    if (nrises < 2) begin
      frames[nrises] = cap;
      fbits[nrises] = nbits;
    end
    nrises++;
    rise_t = $realtime;
  end

  always @(negedge clk) begin
    if (rsp_valid) begin
      rsp_cnt++;
      got_data = rsp_data;
      got_status = rsp_status;
      got_error = rsp_error;
      got_raw = rsp_raw;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_cmd(input logic [1:0] k, input logic [7:0] a, input logic [15:0] d);
    logic [31:0] w;
    case (k)
      2'b00: w = 32'h2000_0000;
      2'b01: w = 32'h8000_0000;
      default: w = 32'h4000_0000;
    endcase
    if (k != 2'b00) w = w | ({24'h0, a & 8'hFE} << 17);
    if (k == 2'b10) w = w | ({16'h0, d} << 1);
    if (($countones(w) % 2) == 0) w = w | 32'h1;
    return w;
  endfunction

  task automatic run_txn(input logic [1:0] k, input logic [7:0] a, input logic [15:0] d, input logic [31:0] reply);
    logic [31:0] ec;
    realtime ready_t;
    int waited;
    slave_word = reply;
    nfalls = 0;
    nrises = 0;
    rsp_cnt = 0;
    frames[0] = 'x;
    frames[1] = 'x;
    @(negedge clk);
    req_valid = 1'b1;
    req_kind = k;
    req_addr = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_kind = $urandom_range(0, 3);
    req_addr = $urandom;
    req_wdata = $urandom;
    waited = 0;
    while (!req_ready && waited < 8000) begin
      @(negedge clk);
      waited++;
    end
    ready_t = $realtime;
    repeat (3) @(negedge clk);
    chk(waited < 8000, "R11 ready returns", waited, 0);
    ec = exp_cmd(k, a, d);
    if (k == 2'b11) begin
      chk(nfalls == 0, "R11 kind 11 no frame", nfalls, 0);
      chk(rsp_cnt == 0, "R11 kind 11 no response", rsp_cnt, 0);
      return;
    end
    chk(fbits[0] == 32, "R1 sck pulses per frame", fbits[0], 32);
    chk(frames[0][31:29] == ec[31:29], "R2 opcode", frames[0][31:29], ec[31:29]);
    chk(frames[0][28:17] == ec[28:17], "R3 address field", frames[0][28:17], ec[28:17]);
    chk(frames[0][16:1] == ec[16:1], "R4 data field", frames[0][16:1], ec[16:1]);
    chk(frames[0][0] == ec[0] && ($countones(frames[0]) % 2 == 1), "R5 parity", frames[0], ec);
    if (k == 2'b10) begin
      chk(nfalls == 1, "R10 single frame", nfalls, 1);
      chk(rsp_cnt == 0, "R10 no response", rsp_cnt, 0);
      chk((ready_t - rise_t) >= QUIET_CYC * 20.0, "R10 quiet interval", int'(ready_t - rise_t), QUIET_CYC * 20);
    end else begin
      chk(nfalls == 2, "R6 two frames", nfalls, 2);
      chk(fbits[1] == 32, "R1 reply frame pulses", fbits[1], 32);
      chk(frames[1] == 32'h0, "R6 reply frame mosi zero", frames[1], 0);
      chk(gap_t >= GAP_CYC * 20.0, "R6 inter-frame gap", int'(gap_t), GAP_CYC * 20);
      chk(rsp_cnt == 1, "R9 one response pulse", rsp_cnt, 1);
      if (k == 2'b01)
        chk(got_data == reply[20:5], "R7 register value", got_data, reply[20:5]);
      else
        chk(got_data == reply[25:10], "R8 rate value", got_data, reply[25:10]);
      chk(got_status == reply[27:26], "R9 status", got_status, reply[27:26]);
      chk(got_error == reply[31:29], "R9 error", got_error, reply[31:29]);
      chk(got_raw == reply, "R9 raw reply", got_raw, reply);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 reset cs_n high", cs_n, 1);
    chk(sck == 1'b0, "R1 reset sck low", sck, 0);
    chk(req_ready == 1'b1, "R11 reset ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R9 reset no response", rsp_valid, 0);

    run_txn(2'b00, 8'h00, 16'h0000, 32'hE800_0000 | (32'h8001 << 10));
    run_txn(2'b01, 8'h0B, 16'h0000, 32'h5FFF_FFE0);
    run_txn(2'b01, 8'h0A, 16'h0000, 32'h0000_0000);
    run_txn(2'b10, 8'h12, 16'h0003, 32'h0);
    run_txn(2'b10, 8'h13, 16'h0001, 32'h0);
    run_txn(2'b11, 8'h0C, 16'hFFFF, 32'hFFFF_FFFF);
    run_txn(2'b00, 8'hFF, 16'hFFFF, 32'h1FFF_FFFF);

    for (int i = 0; i < 24; i++) begin
      logic [1:0] k;
      k = $urandom_range(0, 3);
      if (k == 2'b10 && ($urandom_range(0, 2) != 0)) k = 2'b01;
      run_txn(k, 8'($urandom), 16'($urandom), $urandom);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule